// File: doc/BRIEF.md
# Serial-Bus Byte Memory Target

This block is a byte-wide memory that a host reaches over a four-wire serial bus: an active-low select, a serial clock, a host-to-target data line and a target-to-host data line. A pause input can also stall a transfer in mid-stream. Every transaction opens with an 8-bit command. A memory read or write then takes a 16-bit address and streams data bytes. The status commands move a single byte to or from a small mode register. That register decides how the internal address pointer moves after each data byte. In single-byte mode the transfer stops after one byte. In page mode the pointer wraps inside an aligned 32-byte block. In sequential mode the pointer runs through the whole array and rolls over at the top.

The serial inputs are oversampled by the chip's core clock, so they must already be synchronised to it. The serial clock must stay low for at least two core cycles and high for at least two core cycles. The output data line comes with an output-enable for the pad.

Top module: `spi_sram_slave`

## Requirements
- R1: Bits are taken from `mosi` on each rising edge of `sck` while `csN` is low and `holdN` is high, most significant bit first. The first sample is the first rising edge after `csN` falls. Command codes: 0x03 reads memory, 0x02 writes memory, 0x05 reads status, 0x01 writes status.
- R2: After the read or write command comes a 16-bit address, high byte first. Only its low `ADDR_W` bits select the byte; all higher bits are ignored. Read data leaves on `miso` most significant bit first. `miso` changes after each falling edge of `sck`, so the host can sample it on the following rising edge.
- R3: A written byte reaches the array only after all 8 of its bits are in. A partial byte cut off by `csN` rising leaves the array unchanged.
- R4: Status bits 7:6 hold the mode: 00 single byte, 10 page, 01 sequential. After reset they are 00. Status reads return the mode in bits 7:6 and zeros below. A status write changes only bits 7:6.
- R5: In single-byte mode one data byte is moved after the address. Further clocks read nothing and write nothing, and `misoOe` stays low.
- R6: In page mode the pointer steps within the 32-byte page. From offset 31 it returns to offset 0 of the same page.
- R7: In sequential mode the pointer steps across page boundaries. From the top address 2^ADDR_W-1 it rolls over to 0.
- R8: Raising `csN` ends any transfer at once. The next transaction starts with a new command, whatever bit the previous one stopped at.
- R9: While `csN` is low and `holdN` is low, `sck` and `mosi` are ignored and the transfer is frozen. Once `holdN` returns high, the transfer resumes from the bit where it paused.
- R10: `misoOe` is high only while `csN` is low, `holdN` is high and a memory read or status read is in its data phase.
- R11: Any other command code is ignored until `csN` rises. No data is driven, and neither the array nor the status changes.
- R12: Mode value 11 behaves exactly like single-byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low select; a rising edge ends the transaction |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low pause |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output-enable for the `miso` pad |

## Verification
Some properties are checked on every core cycle. Select-high returns the sequencer to command phase with a zero bit count. A pause with select low freezes the sequencer. The output-enable stays low while extra clocks are being ignored. Single-byte mode leaves the data phase after one byte. In page mode the pointer keeps its page and steps by one. In sequential mode it steps by one modulo the array size. The status changes only on a status-write strobe. Other behaviour shows only through the bench's transactions against a reference array: data values, rollover at the top address, a partial byte being dropped, a paused transfer resuming at the exact bit, and an unknown command touching nothing.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  typedef enum logic [1:0] {
    MODE_BYTE = 2'b00,
    MODE_SEQ  = 2'b01,
    MODE_PAGE = 2'b10,
    MODE_RSVD = 2'b11
  } modeT;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR_H,
    PH_ADDR_L,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_RD_STAT,
    PH_WR_STAT,
    PH_IGNORE
  } phaseT;

  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;

  typedef struct packed {
    logic       sample;
    logic       drive;
    logic [2:0] bitIdx;
    logic       loadHi;
    logic       loadPtr;
    logic       memWr;
    logic       advance;
    logic       statWr;
    logic       selStat;
  } ctrlStrobesT;

endpackage

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl
  import spi_sram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic        holdN,
  input  logic [7:0]  rxNext,
  input  modeT        mode,
  output ctrlStrobesT strb,
  output logic        misoOe
);

  logic       sckPrev;
  logic [2:0] bitCnt;
  phaseT      phase;
  phaseT      phaseNext;
  logic       isWrite;
  logic       active;
  logic       rise;
  logic       fall;
  logic       byteDone;
  logic       singleByte;
  logic       outPhase;

  assign active     = !csN && holdN;
  assign rise       = active && sck && !sckPrev;
  assign fall       = active && !sck && sckPrev;
  assign byteDone   = rise && (bitCnt == 3'd7);
  assign singleByte = (mode != MODE_PAGE) && (mode != MODE_SEQ);
  assign outPhase   = (phase == PH_RD_DATA) || (phase == PH_RD_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sck;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_CMD: begin
        case (rxNext)
          OP_MEM_RD, OP_MEM_WR: phaseNext = PH_ADDR_H;
          OP_STAT_RD:           phaseNext = PH_RD_STAT;
          OP_STAT_WR:           phaseNext = PH_WR_STAT;
          default:              phaseNext = PH_IGNORE;
        endcase
      end
      PH_ADDR_H:  phaseNext = PH_ADDR_L;
      PH_ADDR_L:  phaseNext = isWrite ? PH_WR_DATA : PH_RD_DATA;
      PH_RD_DATA: phaseNext = singleByte ? PH_IGNORE : PH_RD_DATA;
      PH_WR_DATA: phaseNext = singleByte ? PH_IGNORE : PH_WR_DATA;
      PH_RD_STAT: phaseNext = PH_IGNORE;
      PH_WR_STAT: phaseNext = PH_IGNORE;
      PH_IGNORE:  phaseNext = PH_IGNORE;
      default:    phaseNext = PH_IGNORE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      phase   <= PH_CMD;
      bitCnt  <= 3'd0;
      isWrite <= 1'b0;
    end else begin
      if (rise) bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        phase <= phaseNext;
        if (phase == PH_CMD) isWrite <= (rxNext == OP_MEM_WR);
      end
    end
  end

  always_comb begin
    strb.sample  = rise;
    strb.drive   = fall && outPhase;
    strb.bitIdx  = bitCnt;
    strb.loadHi  = byteDone && (phase == PH_ADDR_H);
    strb.loadPtr = byteDone && (phase == PH_ADDR_L);
    strb.memWr   = byteDone && (phase == PH_WR_DATA);
    strb.advance = byteDone && ((phase == PH_RD_DATA) || (phase == PH_WR_DATA));
    strb.statWr  = byteDone && (phase == PH_WR_STAT);
    strb.selStat = (phase == PH_RD_STAT);
  end

  assign misoOe = active && outPhase;

  AST_CS_IDLE_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (phase == PH_CMD) && (bitCnt == 3'd0)); // R8

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !holdN) |=> csN || ($stable(bitCnt) && $stable(phase))); // R9

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE) |-> !misoOe); // R5

  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && singleByte && ((phase == PH_RD_DATA) || (phase == PH_WR_DATA)))
    |=> (phase == PH_IGNORE) || (phase == PH_CMD)); // R12

endmodule

// File: rtl/spi_sram_dp.sv
module spi_sram_dp
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mosi,
  input  ctrlStrobesT strb,
  output logic [7:0]  rxNext,
  output modeT        statMode,
  output logic        miso
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [6:0]        shiftReg;
  logic [7:0]        addrHi;
  logic [15:0]       addrFull;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptrSeq;
  logic [ADDR_W-1:0] ptrPage;
  logic [ADDR_W-1:0] ptrNext;
  logic [7:0]        txByte;
  logic [7:0]        mem [DEPTH];

  assign rxNext   = {shiftReg, mosi};
  assign addrFull = {addrHi, rxNext};
  assign ptrSeq   = ptr + ADDR_W'(1);

  generate
    if (PAGE_W < ADDR_W) begin : g_paged
      assign ptrPage = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
    end else begin : g_flat
      assign ptrPage = ptrSeq;
    end
  endgenerate

  always_comb begin
    unique case (statMode)
      MODE_SEQ:  ptrNext = ptrSeq;
      MODE_PAGE: ptrNext = ptrPage;
      default:   ptrNext = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= 7'd0;
      addrHi   <= 8'd0;
      ptr      <= '0;
      statMode <= MODE_BYTE;
      miso     <= 1'b0;
    end else begin
      if (strb.sample)  shiftReg <= rxNext[6:0];
      if (strb.loadHi)  addrHi   <= rxNext;
      if (strb.loadPtr) ptr      <= addrFull[ADDR_W-1:0];
      if (strb.advance) ptr      <= ptrNext;
      if (strb.statWr)  statMode <= modeT'(rxNext[7:6]);
      if (strb.drive)   miso     <= txByte[~strb.bitIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[ptr] <= rxNext;
  end

  assign txByte = strb.selStat ? {statMode, 6'd0} : mem[ptr];

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadHi, strb.loadPtr, strb.statWr, strb.memWr})); // R1

  AST_STATUS_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statWr |=> $stable(statMode)); // R4

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && statMode == MODE_SEQ) |=> ptr == $past(ptr) + ADDR_W'(1)); // R7

  generate
    if (PAGE_W < ADDR_W) begin : g_page_chk
      AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
        (strb.advance && statMode == MODE_PAGE)
        |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
            (ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + PAGE_W'(1))); // R6
    end
  endgenerate

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic holdN,
  output logic miso,
  output logic misoOe
);

  ctrlStrobesT strb;
  logic [7:0]  rxNext;
  modeT        statMode;

  spi_sram_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sck    (sck),
    .holdN  (holdN),
    .rxNext (rxNext),
    .mode   (statMode),
    .strb   (strb),
    .misoOe (misoOe)
  );

  spi_sram_dp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .mosi     (mosi),
    .strb     (strb),
    .rxNext   (rxNext),
    .statMode (statMode),
    .miso     (miso)
  );

endmodule

// File: tb/spi_sram_slave_tb.sv
module spi_sram_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int AW         = 10;
  localparam int DEPTH      = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic holdN = 1'b1;
  logic miso;
  logic misoOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sram_slave #(.ADDR_W(AW), .PAGE_W(5)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .holdN(holdN), .miso(miso), .misoOe(misoOe)
  );

  typedef struct { logic [7:0] val; logic oe; string req; } expT;
  typedef struct { logic [7:0] val; logic oeAll; logic oeAny; } obsT;

  expT expQ[$];
  obsT obsQ[$];
  expT mE;
  obsT mO;
  int checks = 0;
  int failures = 0;
  logic [7:0] refMem [DEPTH];
  logic [1:0] refMode = 2'b00;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares observed bytes with the expectations in order
  always @(negedge clk) begin
    while (expQ.size() > 0 && obsQ.size() > 0) begin
      mE = expQ.pop_front();
      mO = obsQ.pop_front();
      if (mE.oe)
        chk(mO.oeAll === 1'b1 && mO.val === mE.val, mE.req, "read byte",
            int'(mO.val), int'(mE.val));
      else
        chk(mO.oeAny === 1'b0, mE.req, "output enable quiet", int'(mO.oeAny), 0);
    end
  end

  task automatic tick();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bitX(input logic b, output logic r, output logic oe);
    mosi = b; tick();
    r = miso; oe = misoOe;
    sck = 1'b1; tick();
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oeAll, output logic oeAny);
    oeAll = 1'b1; oeAny = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic r, o;
      bitX(tx[i], r, o);
      rx[i] = r; oeAll &= o; oeAny |= o;
    end
  endtask

  task automatic txb(input logic [7:0] tx);
    logic [7:0] rx; logic a, b;
    xfer(tx, rx, a, b);
  endtask

  task automatic rxObs(input logic [7:0] tx);
    logic [7:0] rx; logic a, b;
    xfer(tx, rx, a, b);
    obsQ.push_back('{val: rx, oeAll: a, oeAny: b});
  endtask

  task automatic csLow();  csN = 1'b0; tick(); endtask
  task automatic csHigh(); tick(); csN = 1'b1; tick(); endtask

  function automatic int nxt(input int a);
    case (refMode)
      2'b01:   return (a + 1) % DEPTH;
      2'b10:   return (a & ~31) | ((a + 1) & 31);
      default: return a;
    endcase
  endfunction

  function automatic bit single();
    return (refMode == 2'b00) || (refMode == 2'b11);
  endfunction

  task automatic wrBytes(input logic [15:0] a, input logic [7:0] d[$]);
    int p;
    p = int'(a[AW-1:0]);
    csLow(); txb(8'h02); txb(a[15:8]); txb(a[7:0]);
    for (int i = 0; i < d.size(); i++) begin
      txb(d[i]);
      if (i == 0 || !single()) begin refMem[p] = d[i]; p = nxt(p); end
    end
    csHigh();
  endtask

  task automatic rdBytes(input logic [15:0] a, input int n, input string req);
    int p;
    p = int'(a[AW-1:0]);
    csLow(); txb(8'h03); txb(a[15:8]); txb(a[7:0]);
    for (int i = 0; i < n; i++) begin
      if (i == 0 || !single()) begin
        expQ.push_back('{val: refMem[p], oe: 1'b1, req: req});
        p = nxt(p);
      end else expQ.push_back('{val: 8'h00, oe: 1'b0, req: req});
      rxObs(8'h00);
    end
    csHigh();
  endtask

  task automatic setStat(input logic [7:0] v);
    csLow(); txb(8'h01); txb(v); csHigh();
    refMode = v[7:6];
  endtask

  task automatic rdStat(input string req);
    csLow(); txb(8'h05);
    expQ.push_back('{val: {refMode, 6'd0}, oe: 1'b1, req: req});
    rxObs(8'h00);
    expQ.push_back('{val: 8'h00, oe: 1'b0, req: req});
    rxObs(8'h00);
    csHigh();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] fill[$];
    logic [7:0] rx;
    logic r, o, oeSeen;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10: idle output enable after reset
    chk(misoOe === 1'b0, "R10", "oe after reset", int'(misoOe), 0);
    // R4: reset mode 00
    rdStat("R4");

    // R7: fill the whole array in sequential mode, two extra bytes roll over
    setStat(8'h40);
    for (int i = 0; i < DEPTH + 2; i++) fill.push_back(8'((i * 7 + 3) ^ (i >> 3)));
    fill[DEPTH] = 8'hE1; fill[DEPTH + 1] = 8'h1E;
    wrBytes(16'h0000, fill);
    rdBytes(16'h03FE, 4, "R7");
    rdBytes(16'h001F, 2, "R7");
    rdBytes(16'h0005, 3, "R1");
    // R2: upper address bits ignored
    rdBytes(16'hFC40, 2, "R2");

    // R6: page wrap on write and read
    setStat(8'h80);
    wrBytes(16'h0A3E, {8'hC1, 8'hC2, 8'hC3, 8'hC4});
    rdBytes(16'h023F, 3, "R6");

    // R3: partial byte discarded
    setStat(8'h40);
    csLow(); txb(8'h02); txb(8'h01); txb(8'h00); txb(8'h11);
    for (int i = 0; i < 5; i++) bitX(1'b1, r, o);
    csHigh();
    refMem[16'h100] = 8'h11;
    rdBytes(16'h0100, 2, "R3");

    // R8: abort mid-address and mid-command, then fresh transactions
    csLow(); txb(8'h03); txb(8'h01);
    for (int i = 0; i < 3; i++) bitX(1'b1, r, o);
    csHigh();
    rdStat("R8");
    csLow();
    for (int i = 0; i < 4; i++) bitX(1'b0, r, o);
    csHigh();
    rdBytes(16'h0200, 1, "R8");

    // R9: pause during a read data byte
    csLow(); txb(8'h03); txb(8'h01); txb(8'h55);
    rx = 8'h00;
    for (int i = 7; i >= 5; i--) begin bitX(1'b0, r, o); rx[i] = r; end
    holdN = 1'b0; tick();
    oeSeen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      mosi = k[0]; sck = 1'b1; tick(); oeSeen |= misoOe; sck = 1'b0; tick();
      oeSeen |= misoOe;
    end
    chk(oeSeen === 1'b0, "R10", "oe during pause", int'(oeSeen), 0);
    holdN = 1'b1;
    for (int i = 4; i >= 0; i--) begin bitX(1'b0, r, o); rx[i] = r; end
    csHigh();
    chk(rx === refMem[16'h155], "R9", "byte across pause", int'(rx), int'(refMem[16'h155]));

    // R9: pause during a write address byte
    csLow(); txb(8'h02); txb(8'h02);
    for (int i = 7; i >= 4; i--) bitX(1'(8'hAA >> i), r, o);
    holdN = 1'b0; tick();
    for (int k = 0; k < 3; k++) begin
      mosi = ~k[0]; sck = 1'b1; tick(); sck = 1'b0; tick();
    end
    holdN = 1'b1;
    for (int i = 3; i >= 0; i--) bitX(1'(8'hAA >> i), r, o);
    txb(8'h3C); csHigh();
    refMem[16'h2AA] = 8'h3C;
    rdBytes(16'h02AA, 1, "R9");

    // R11: unknown command drives nothing and changes nothing
    csLow(); txb(8'h9F);
    expQ.push_back('{val: 8'h00, oe: 1'b0, req: "R11"}); rxObs(8'h02);
    expQ.push_back('{val: 8'h00, oe: 1'b0, req: "R11"}); rxObs(8'h00);
    txb(8'h00); txb(8'h77); txb(8'h01);
    csHigh();
    rdBytes(16'h0000, 2, "R11");
    rdStat("R11");

    // R5: single-byte mode, second byte neither written nor driven
    setStat(8'h00);
    wrBytes(16'h8123, {8'hA5, 8'h5A});
    rdBytes(16'h0123, 2, "R5");
    rdBytes(16'h0124, 1, "R5");

    // R4 / R12: only bits 7:6 stick, mode 11 acts like single byte
    setStat(8'hFF);
    rdStat("R4");
    rdBytes(16'h0010, 2, "R12");
    wrBytes(16'h0030, {8'h9A, 8'h9B});
    rdBytes(16'h0031, 1, "R12");
    setStat(8'h40);
    rdBytes(16'h0030, 2, "R12");

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0 && obsQ.size() == 0, "R1", "scoreboard drained",
        expQ.size() + obsQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule